// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the byte-level protocol engine of a small serial memory and its 128-byte storage array. During a write transfer the engine first loads the word pointer and then passes each received data byte with a one-cycle strobe. Each byte lands in an eight-entry page latch selected by the low three pointer bits. After each byte only those three bits advance, wrapping inside the page, so a long transfer overwrites its own earlier entries.

When a stop ends the transfer, the block checks the write-protect input and whether any entry was written. If both allow it, the block walks the eight latch entries in index order, one per cycle, and drives an array write for each entry that holds data. The address is the fixed page number joined to the entry index. Busy stays high for a parameterised number of cycles that models the self-timed program cycle. Bytes, pointer loads and stops that arrive while busy is high are ignored. A repeated start, a protected stop or an empty transfer drops the latch contents without starting a cycle.

Controller states: `ST_COLLECT` (idle, gathering bytes), `ST_PROGRAM` (scanning the eight entries and issuing array writes) and `ST_SETTLE` (the rest of the timed cycle). The transitions are:
- `go_program`: `ST_COLLECT` to `ST_PROGRAM`, on a stop while protection is off and at least one entry is filled.
- `scan_done`: `ST_PROGRAM` to `ST_SETTLE`, after entry 7.
- `cycle_end`: `ST_SETTLE` to `ST_COLLECT`, when the write time has elapsed.
- `drop`: `ST_COLLECT` to `ST_COLLECT`, on a stop that does not commit or on a repeated start; the latch is cleared.

Top module: `page_commit_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, busy and arr_we are 0.
- R2: A byte strobe stores wr_data into latch entry ptr[2:0]. ptr[2:0] then increments modulo 8 and ptr[6:3] is unchanged. ptr_load sets the whole 7-bit pointer.
- R3: No array write happens before a stop. Committing starts in the cycle after the stop edge. Entry k is examined in the k-th busy cycle (k = 0..7), and arr_we is high there only if entry k was written, with arr_addr = {ptr[6:3], k} and arr_wdata = the entry's value.
- R4: When more than eight bytes are sent, the extra bytes wrap and overwrite earlier entries, and each entry commits the last value written to it.
- R5: A committing stop raises busy for exactly WRITE_CYCLES consecutive cycles, starting in the cycle after the stop edge.
- R6: prot_n low (0 = protected) blocks all array writes. A stop sampled with prot_n low starts no cycle and leaves busy at 0, and the latched data is discarded.
- R7: A stop with no byte written since the last commit or drop starts no cycle, and busy stays 0.
- R8: A repeated-start strobe discards all latched data without writing the array.
- R9: While busy is high, wr_stb, ptr_load and stop_stb have no effect: the pointer, the latch and the busy length are unchanged.
- R10: Every entry is cleared at the end of a write cycle, so the next transfer commits only the entries it writes itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr_load | input | 1 | Load the word pointer from ptr_val |
| ptr_val | input | 7 | Word address received from the bus |
| wr_stb | input | 1 | One-cycle strobe for a received data byte |
| wr_data | input | 8 | Data byte |
| stop_stb | input | 1 | Stop ended the current transfer |
| rstart_stb | input | 1 | Repeated start aborted the current transfer |
| prot_n | input | 1 | Write-protect input, 0 = protected |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The bench sets WRITE_CYCLES to 24. With that value a whole write cycle takes a few dozen clocks, so every busy window can be measured sample by sample. Thirty random transfers, with empty, partial, full and wrapping pages, fit easily within the cycle limit. The eight-entry page and 7-bit pointer are kept at their defaults. The page wrap, the page-number bits and the commit order are therefore checked at the real geometry. A directed case drives bytes, a pointer load and a stop into the middle of a busy window to show that they are ignored.

// File: rtl/pagebuf_pkg.sv
package pagebuf_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_PROGRAM = 2'd1,
        ST_SETTLE  = 2'd2
    } wstate_e;
endpackage

// File: rtl/page_latch.sv
module page_latch #(
    parameter int DW        = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic                 clr,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [DW-1:0]        rd_data,
    output logic                 rd_valid,
    output logic                 any_valid
);
    localparam int ENTRIES = 1 << PAGE_BITS;

    logic [DW-1:0]      store [ENTRIES];
    logic [ENTRIES-1:0] vld;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[g]   <= 1'b0;
                store[g] <= '0;
            end else if (clr) begin
                vld[g]   <= 1'b0;
            end else if (we && (wr_idx == PAGE_BITS'(g))) begin
                vld[g]   <= 1'b1;
                store[g] <= wr_data;
            end
        end
    end

    assign rd_data   = store[rd_idx];
    assign rd_valid  = vld[rd_idx];
    assign any_valid = |vld;
endmodule

// File: rtl/commit_timer.sv
module commit_timer #(
    parameter int WRITE_CYCLES = 1000,
    parameter int PAGE_BITS    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    output logic [PAGE_BITS-1:0] scan_idx,
    output logic                 scan_last,
    output logic                 cyc_last
);
    localparam int CW      = $clog2(WRITE_CYCLES + 1);
    localparam int ENTRIES = 1 << PAGE_BITS;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + CW'(1);
        else          cnt <= '0;
    end

    assign scan_idx  = cnt[PAGE_BITS-1:0];
    assign scan_last = (cnt == CW'(ENTRIES - 1));
    assign cyc_last  = (cnt == CW'(WRITE_CYCLES - 1));
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pagebuf_pkg::*;
#(
    parameter int AW           = 7,
    parameter int DW           = 8,
    parameter int PAGE_BITS    = 3,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_val,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          stop_stb,
    input  logic          rstart_stb,
    input  logic          prot_n,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          busy
);
    localparam int PB = PAGE_BITS;

    wstate_e        state, state_nx;
    logic [AW-1:0]  ptr;
    logic [PB-1:0]  scan_idx;
    logic           scan_last, cyc_last;
    logic [DW-1:0]  rd_data;
    logic           rd_valid, any_valid;
    logic           idle, go_program, lat_we, lat_clr, ptr_upd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_nx;
    end

    // next state and transition decode
    always_comb begin
        state_nx   = state;
        go_program = 1'b0;
        unique case (state)
            ST_COLLECT: begin
                if (stop_stb && any_valid && prot_n) begin
                    go_program = 1'b1;
                    state_nx   = ST_PROGRAM;
                end
            end
            ST_PROGRAM: if (scan_last) state_nx = ST_SETTLE;
            ST_SETTLE:  if (cyc_last)  state_nx = ST_COLLECT;
            default:    state_nx = ST_COLLECT;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        idle    = (state == ST_COLLECT);
        busy    = !idle;
        arr_we  = 1'b0;
        lat_clr = 1'b0;
        unique case (state)
            ST_COLLECT: lat_clr = (stop_stb && !go_program) || rstart_stb;
            ST_PROGRAM: arr_we  = rd_valid && prot_n;
            ST_SETTLE:  lat_clr = cyc_last;
            default:    lat_clr = 1'b1;
        endcase
        lat_we  = idle && wr_stb && !ptr_load && !stop_stb && !rstart_stb;
        ptr_upd = idle && ptr_load && !stop_stb && !rstart_stb;
    end

    assign arr_addr  = {ptr[AW-1:PB], scan_idx};
    assign arr_wdata = rd_data;

    // word pointer: low bits wrap inside the page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (ptr_upd) ptr <= ptr_val;
        else if (lat_we)  ptr <= {ptr[AW-1:PB], ptr[PB-1:0] + PB'(1)};
    end

    page_latch #(.DW(DW), .PAGE_BITS(PB)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (lat_we),
        .wr_idx    (ptr[PB-1:0]),
        .wr_data   (wr_data),
        .clr       (lat_clr),
        .rd_idx    (scan_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    commit_timer #(.WRITE_CYCLES(WRITE_CYCLES), .PAGE_BITS(PB)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .scan_idx  (scan_idx),
        .scan_last (scan_last),
        .cyc_last  (cyc_last)
    );
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
    parameter int AW           = 7,
    parameter int PAGE_BITS    = 3,
    parameter int WRITE_CYCLES = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_stb,
    input logic          prot_n,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr,
    input logic          busy
);
    localparam int CW      = $clog2(WRITE_CYCLES + 1);
    localparam int ENTRIES = 1 << PAGE_BITS;
    localparam logic [CW-1:0] W_L = CW'(WRITE_CYCLES);

    logic [CW-1:0] blen;
    logic [PAGE_BITS:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blen <= '0;
            wcnt <= '0;
        end else begin
            blen <= busy ? blen + CW'(1) : '0;
            wcnt <= busy ? wcnt + (PAGE_BITS+1)'(arr_we) : '0;
        end
    end

    p_prot_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> prot_n);
    p_write_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (blen == W_L));
    p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen < W_L));
    p_busy_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb));
    p_protected_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && !prot_n) |=> !busy);
    p_page_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (wcnt < (PAGE_BITS+1)'(ENTRIES)));
    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (arr_addr[AW-1:PAGE_BITS] == $past(arr_addr[AW-1:PAGE_BITS])));
endmodule

bind page_commit_buf page_commit_chk #(
    .AW(AW), .PAGE_BITS(PAGE_BITS), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_stb (stop_stb),
    .prot_n   (prot_n),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .busy     (busy)
);

// File: tb/sim_page_commit_buf.sv
module sim_page_commit_buf;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 24;
    localparam int AW = 7;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_load = 1'b0, wr_stb = 1'b0, stop_stb = 1'b0, rstart_stb = 1'b0;
    logic          prot_n = 1'b1;
    logic [AW-1:0] ptr_val = '0;
    logic [DW-1:0] wr_data = '0;
    logic          arr_we, busy;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench model
    logic [7:0] m_lat [8];
    bit         m_val [8];
    logic [6:0] m_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_commit_buf #(.WRITE_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val),
        .wr_stb(wr_stb), .wr_data(wr_data), .stop_stb(stop_stb),
        .rstart_stb(rstart_stb), .prot_n(prot_n), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit any_val();
        for (int k = 0; k < 8; k++) if (m_val[k]) return 1;
        return 0;
    endfunction

    function automatic void clear_model();
        for (int k = 0; k < 8; k++) m_val[k] = 0;
    endfunction

    task automatic load_ptr(input logic [6:0] a);
        @(negedge clk); ptr_load = 1; ptr_val = a; m_ptr = a;
        @(negedge clk); ptr_load = 0;
    endtask

    // R2: model entry select and in-page increment
    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_stb = 1; wr_data = d;
        m_lat[m_ptr[2:0]] = d; m_val[m_ptr[2:0]] = 1;
        m_ptr = {m_ptr[6:3], m_ptr[2:0] + 3'd1};
        @(negedge clk); wr_stb = 0;
    endtask

    task automatic rstart();
        @(negedge clk); rstart_stb = 1;
        @(negedge clk); rstart_stb = 0;
        clear_model();  // R8
    endtask

    // stop, then check the whole busy window (R3, R5, R6, R7, R9, R10)
    task automatic do_stop(input bit inject, input string tag);
        bit go;
        go = any_val() && prot_n;
        @(negedge clk); stop_stb = 1;
        @(negedge clk); stop_stb = 0;
        if (go) begin
            for (int i = 0; i < W; i++) begin
                chk(busy === 1'b1, {tag, " R5 busy"}, busy, 1);
                if (i < 8) begin
                    chk(arr_we === m_val[i], {tag, " R3 we"}, arr_we, m_val[i]);
                    if (m_val[i] && arr_we) begin
                        chk(arr_addr === {m_ptr[6:3], 3'(i)}, {tag, " R3 addr"},
                            arr_addr, {m_ptr[6:3], 3'(i)});
                        chk(arr_wdata === m_lat[i], {tag, " R4 data"}, arr_wdata, m_lat[i]);
                    end
                end else begin
                    chk(arr_we === 1'b0, {tag, " R3 we late"}, arr_we, 0);
                end
                // R9: strobes while busy
                if (inject && i == 12) begin
                    wr_stb = 1; wr_data = 8'hEE; ptr_load = 1; ptr_val = 7'h7F; stop_stb = 1;
                end else if (inject) begin
                    wr_stb = 0; ptr_load = 0; stop_stb = 0;
                end
                @(negedge clk);
            end
            chk(busy === 1'b0, {tag, " R5 busy end"}, busy, 0);
        end else begin
            chk(busy === 1'b0, {tag, " R7 no cycle"}, busy, 0);
            chk(arr_we === 1'b0, {tag, " R6 no write"}, arr_we, 0);
            @(negedge clk);
            chk(busy === 1'b0, {tag, " R7 no cycle 2"}, busy, 0);
        end
        clear_model();  // R10
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_model();
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && arr_we === 1'b0, "R1 reset", {busy, arr_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 1'b0 && arr_we === 1'b0, "R1 after reset", {busy, arr_we}, 0);

        // R2 R3: partial page starting mid-page
        load_ptr(7'h2D);
        write_byte(8'hA1); write_byte(8'hB2); write_byte(8'hC3);
        chk(arr_we === 1'b0 && busy === 1'b0, "R3 nothing before stop", arr_we, 0);
        do_stop(0, "dir_partial");

        // R4: eleven bytes wrap inside page 2
        load_ptr(7'h13);
        for (int k = 0; k < 11; k++) write_byte(8'(8'h40 + k));
        do_stop(0, "dir_wrap");

        // R7: empty transfer
        load_ptr(7'h05);
        do_stop(0, "dir_empty");

        // R6: protected stop discards, next transfer commits only its own byte
        load_ptr(7'h48);
        write_byte(8'h11); write_byte(8'h22);
        prot_n = 0;
        do_stop(0, "dir_prot");
        prot_n = 1;
        write_byte(8'h33);
        do_stop(0, "dir_after_prot R6");

        // R8: repeated start drops the latch
        load_ptr(7'h60);
        write_byte(8'h5A); write_byte(8'h6B); write_byte(8'h7C);
        rstart();
        do_stop(0, "dir_rstart R8");
        write_byte(8'h99);
        do_stop(0, "dir_after_rstart R8");

        // R9: activity during busy is ignored; R10 checked on the next commit
        load_ptr(7'h31);
        write_byte(8'hD0); write_byte(8'hD1);
        do_stop(1, "dir_busy_ignore R9");
        write_byte(8'hE5);
        do_stop(0, "dir_after_busy R10");

        // constrained random transfers
        for (int t = 0; t < 30; t++) begin
            int n, kind;
            load_ptr(7'($urandom_range(0, 127)));
            n = $urandom_range(0, 12);
            for (int k = 0; k < n; k++) write_byte(8'($urandom_range(0, 255)));
            kind = $urandom_range(0, 9);
            if (kind == 0) begin
                rstart();
                do_stop(0, "rnd_rstart R8");
            end else if (kind == 1) begin
                prot_n = 0;
                do_stop(0, "rnd_prot R6");
                prot_n = 1;
            end else begin
                do_stop(kind == 2, "rnd_commit R4");
            end
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule